// File: doc/BRIEF.md
# Frame-Loaded Asynchronous Serial Port

This block is a minimal asynchronous serial port with one transmit line and one receive line and no handshake signals. Software builds every transmit frame itself, including the start bit, the data bits and the stop bit. It writes that frame LSB-first as one 16-bit word. The transmitter shifts the word out, one bit per period, and treats the transmission as finished once the shift register has drained to zero. A one-bit output stage holds the last bit sent. Because that bit is the stop bit, the line rests at 1 afterwards. Any parity is left to software.

The receiver brings the line into the clock domain and removes short glitches. It waits for a falling edge while armed. On that edge it presets its shift register to all ones and starts its rate counter at half the divisor, so that each later sample lands near the middle of a bit. Samples enter at the top of the register and move right. When the start bit drops out of the bottom into a hidden stage, the frame is complete. The register keeps the data bits with the stop bit on top, and software strips the stop bit. Both directions share one 15-bit divisor: a value N gives a bit period of N+1 clocks.

Top module: `frameport`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0, `tx_rej` is 0, `rx_armed` is 1, `rx_done` is 0 and `rx_data` is 0.
- R2: After an accepted write of frame F in the cycle of clock edge E, bit k of F is driven on `txd` from edge E+(k+1)(N+1) for N+1 cycles, where N is the divisor. Bit 0 goes first.
- R3: `tx_busy` is high while any bit of the transmit shift register is 1. It falls at the edge where the highest set bit of F moves to `txd`. After that `txd` holds that bit (1) until the next accepted frame.
- R4: A transmit write is ignored when `tx_busy` is high before the edge that samples it. This includes the edge at which the register empties. A one-cycle `tx_rej` pulse follows the edge, and the frame in progress continues unchanged.
- R5: The divisor register takes `div_wdata` on `div_we`. Counters load the new value at their next reload, so a change alters the bit period of later frames in both directions.
- R6: A low pulse on `rxd` that is shorter than 3 clocks after synchronization does not start a reception. `rx_armed` stays 1 and no `rx_done` appears.
- R7: While armed, a falling edge of the filtered line starts a reception. The first sample comes floor(N/2)+1 clocks after the start and later samples follow every N+1 clocks, so each one falls inside its bit.
- R8: With `rx_len10`=0 the receive register is 9 bits long. For a 10-bit frame F, `rx_data[8:0]` equals F[9:1] and `rx_data[9]` is 0. With `rx_len10`=1 the register is 10 bits long and `rx_data[9:0]` equals F[10:1] of an 11-bit frame.
- R9: `rx_done` is a one-cycle pulse at the sample where the start bit leaves the register. The receiver is armed again in the same cycle, so a start bit that follows straight after the stop bit is caught. `rx_data` holds its value until the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 15 | Divisor value N; bit period is N+1 clocks |
| rx_len10 | input | 1 | Receive register length: 0 selects 9 bits, 1 selects 10 bits |
| tx_we | input | 1 | Transmit frame write strobe |
| tx_wdata | input | 16 | Complete frame, LSB first, with start and stop bits included |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmit shift register not empty |
| tx_rej | output | 1 | One-cycle pulse: a transmit write was ignored |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 10 | Received word with the stop bit on top |
| rx_done | output | 1 | One-cycle pulse: frame complete |
| rx_armed | output | 1 | Receiver waiting for a start edge |

## Verification
In the transmitter, a software write and the shift that empties the register can fall on the same clock edge. The bench counts cycles from the frame write, using the position of the frame's highest set bit, and raises a second write for exactly that edge. It expects the write to be flagged on `tx_rej` and to leave `txd` at 1 with `tx_busy` low. In the receiver, completion and rearming share a cycle. Back-to-back frames whose start bit directly follows the previous stop bit must both reach the scoreboard intact.

// File: rtl/frameport_pkg.sv
package frameport_pkg;
  localparam int DIV_W    = 15;
  localparam int TX_W     = 16;
  localparam int RX_W     = 10;
  localparam int STABLE_N = 3;

  typedef enum logic {
    RXLEN_SHORT = 1'b0,
    RXLEN_LONG  = 1'b1
  } rxlen_e;
endpackage

// File: rtl/frameport_rate.sv
module frameport_rate #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         half,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run & ~restart & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = half ? (div >> 1) : div;
    end else if (run) begin
      if (cnt_q == '0) cnt_d = div;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/frameport_rxfilt.sv
module frameport_rxfilt #(
  parameter int STABLE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic flt,
  output logic fall
);
  localparam int RUN_W = (STABLE_N > 2) ? $clog2(STABLE_N) : 1;

  logic             s1_q, s2_q, flt_q, prev_q;
  logic             s1_d, s2_d, flt_d, prev_d;
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    s1_d   = rxd;
    s2_d   = s1_q;
    prev_d = flt_q;
    flt_d  = flt_q;
    run_d  = '0;
    if (s2_q != flt_q) begin
      if (run_q == RUN_W'(STABLE_N - 1)) flt_d = s2_q;
      else                               run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      flt_q  <= 1'b1;
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      flt_q  <= flt_d;
      prev_q <= prev_d;
      run_q  <= run_d;
    end
  end

  assign flt  = flt_q;
  assign fall = prev_q & ~flt_q;

  // R6
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_q) |-> (!$past(s2_q) && !$past(s2_q, 2) && !$past(s2_q, 3)));
endmodule

// File: rtl/frameport_tx.sv
module frameport_tx #(
  parameter int TX_W  = 16,
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             we,
  input  logic [TX_W-1:0]  wdata,
  output logic             txd,
  output logic             busy,
  output logic             rej
);
  logic [TX_W-1:0] sh_q, sh_d;
  logic            out_q, out_d;
  logic            rej_q, rej_d;
  logic            load, tick;

  assign busy = |sh_q;
  assign load = we & ~busy;

  frameport_rate #(.W(DIV_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .half    (1'b0),
    .run     (busy),
    .div     (div),
    .tick    (tick)
  );

  always_comb begin
    sh_d  = sh_q;
    out_d = out_q;
    rej_d = we & busy;
    if (load) begin
      sh_d = wdata;
    end else if (tick) begin
      out_d = sh_q[0];
      sh_d  = sh_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b1;
      rej_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
      rej_q <= rej_d;
    end
  end

  assign txd = out_q;
  assign rej = rej_q;

  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(out_q));
  // R2
  start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we));
  // R4
  reject_keeps_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy && !tick) |=> (sh_q == $past(sh_q)));
endmodule

// File: rtl/frameport_rx.sv
module frameport_rx #(
  parameter int RX_W  = 10,
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             len_long,
  input  logic             flt,
  input  logic             fall,
  output logic [RX_W-1:0]  data,
  output logic             done,
  output logic             armed
);
  logic [RX_W-1:0] sh_q, sh_d, lane_in;
  logic            hb_q, hb_d;
  logic            armed_q, armed_d;
  logic            done_q, done_d;
  logic            start, tick;

  assign start = fall & armed_q;

  frameport_rate #(.W(DIV_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .half    (1'b1),
    .run     (~armed_q),
    .div     (div),
    .tick    (tick)
  );

  for (genvar i = 0; i < RX_W; i++) begin : g_lane
    if (i == RX_W - 1) begin : g_top
      assign lane_in[i] = len_long ? flt : 1'b1;
    end else if (i == RX_W - 2) begin : g_short_top
      assign lane_in[i] = len_long ? sh_q[i+1] : flt;
    end else begin : g_mid
      assign lane_in[i] = sh_q[i+1];
    end
  end

  always_comb begin
    sh_d    = sh_q;
    hb_d    = hb_q;
    armed_d = armed_q;
    done_d  = 1'b0;
    if (start) begin
      sh_d    = '1;
      hb_d    = 1'b1;
      armed_d = 1'b0;
    end else if (tick) begin
      sh_d = lane_in;
      hb_d = sh_q[0];
      if (!sh_q[0]) begin
        armed_d = 1'b1;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      hb_q    <= 1'b1;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      hb_q    <= hb_d;
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  assign data  = len_long ? sh_q : {1'b0, sh_q[RX_W-2:0]};
  assign done  = done_q;
  assign armed = armed_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  done_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (armed_q && !hb_q));
  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q) && !$past(start)) |-> $stable(sh_q));
endmodule

// File: rtl/frameport.sv
module frameport
  import frameport_pkg::*;
#(
  parameter int DIV_BITS = DIV_W,
  parameter int TX_BITS  = TX_W,
  parameter int RX_BITS  = RX_W,
  parameter int STABLE   = STABLE_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                div_we,
  input  logic [DIV_BITS-1:0] div_wdata,
  input  logic                rx_len10,
  input  logic                tx_we,
  input  logic [TX_BITS-1:0]  tx_wdata,
  output logic                txd,
  output logic                tx_busy,
  output logic                tx_rej,
  input  logic                rxd,
  output logic [RX_BITS-1:0]  rx_data,
  output logic                rx_done,
  output logic                rx_armed
);
  logic [1:0]          rst_pipe_q;
  logic                rst_n_s;
  logic [DIV_BITS-1:0] div_q, div_d;
  logic                flt, fall;
  rxlen_e              len_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  always_comb begin
    div_d = div_q;
    if (div_we) div_d = div_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) div_q <= '0;
    else          div_q <= div_d;
  end

  assign len_sel = rx_len10 ? RXLEN_LONG : RXLEN_SHORT;

  frameport_tx #(.TX_W(TX_BITS), .DIV_W(DIV_BITS)) u_tx (
    .clk   (clk),
    .rst_n (rst_n_s),
    .div   (div_q),
    .we    (tx_we),
    .wdata (tx_wdata),
    .txd   (txd),
    .busy  (tx_busy),
    .rej   (tx_rej)
  );

  frameport_rxfilt #(.STABLE_N(STABLE)) u_filt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .rxd   (rxd),
    .flt   (flt),
    .fall  (fall)
  );

  frameport_rx #(.RX_W(RX_BITS), .DIV_W(DIV_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .div      (div_q),
    .len_long (len_sel == RXLEN_LONG),
    .flt      (flt),
    .fall     (fall),
    .data     (rx_data),
    .done     (rx_done),
    .armed    (rx_armed)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (txd && !tx_busy && rx_armed));
endmodule

// File: tb/frameport_bench.sv
module frameport_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        div_we;
  logic [14:0] div_wdata;
  logic        rx_len10;
  logic        tx_we;
  logic [15:0] tx_wdata;
  logic        txd, tx_busy, tx_rej;
  logic        rxd_drv, loop_en;
  logic        rxd;
  logic [9:0]  rx_data;
  logic        rx_done, rx_armed;

  int checks = 0;
  int errors = 0;
  int per    = 24;
  bit ended  = 0;
  logic [9:0] exp_q[$];
  logic [9:0] last_exp;

  always #5 clk = ~clk;

  assign rxd = loop_en ? txd : rxd_drv;

  frameport u_frameport (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .rx_len10  (rx_len10),
    .tx_we     (tx_we),
    .tx_wdata  (tx_wdata),
    .txd       (txd),
    .tx_busy   (tx_busy),
    .tx_rej    (tx_rej),
    .rxd       (rxd),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .rx_armed  (rx_armed)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected rx_done", 32'(rx_data), 32'h0);
      end else begin
        last_exp = exp_q.pop_front();
        chk(rx_data == last_exp, "R8 received word", 32'(rx_data), 32'(last_exp));
      end
    end
  end

  task automatic set_div(input int n);
    @(negedge clk);
    div_we = 1'b1; div_wdata = 15'(n);
    @(negedge clk);
    div_we = 1'b0;
    per = n + 1;
  endtask

  function automatic logic [9:0] rx_expect(input logic [15:0] fr);
    if (rx_len10) return fr[10:1];
    return {1'b0, fr[9:1]};
  endfunction

  // hit: bit index for a mid-frame write; at_end: write on the emptying edge
  task automatic tx_frame(input logic [15:0] f, input int hit, input bit at_end);
    int h = 0;
    int wait_n;
    for (int i = 0; i < 16; i++) if (f[i]) h = i;
    @(negedge clk);
    tx_we = 1'b1; tx_wdata = f;
    @(negedge clk);
    tx_we = 1'b0;
    chk(tx_busy == 1'b1, "R3 busy after write", 32'(tx_busy), 32'h1);
    wait_n = per + per / 2;
    for (int k = 0; k <= h; k++) begin
      repeat (wait_n) @(negedge clk);
      chk(txd == f[k], "R2 txd bit", 32'(txd), 32'(f[k]));
      wait_n = per;
      if (k == h)
        chk(tx_busy == 1'b0, "R3 busy falls at last bit", 32'(tx_busy), 32'h0);
      if (k == hit) begin
        tx_we = 1'b1; tx_wdata = ~f;
        @(negedge clk);
        tx_we = 1'b0;
        chk(tx_rej == 1'b1, "R4 reject mid frame", 32'(tx_rej), 32'h1);
        wait_n = per - 1;
      end
      if (at_end && k == h - 1) begin
        repeat (per / 2 - 1) @(negedge clk);
        tx_we = 1'b1; tx_wdata = 16'h0003;
        @(negedge clk);
        tx_we = 1'b0;
        chk(tx_rej == 1'b1, "R4 reject on emptying edge", 32'(tx_rej), 32'h1);
        chk(tx_busy == 1'b0, "R4 no restart on emptying edge", 32'(tx_busy), 32'h0);
        wait_n = per / 2;
      end
    end
    begin
      bit held = 1'b1;
      for (int i = 0; i < 2 * per; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || tx_busy !== 1'b0) held = 1'b0;
      end
      chk(held, "R3 line idle after frame", 32'(held), 32'h1);
    end
  endtask

  task automatic rx_send(input logic [15:0] fr, input int nb);
    exp_q.push_back(rx_expect(fr));
    for (int k = 0; k < nb; k++) begin
      rxd_drv = fr[k];
      repeat (per) @(negedge clk);
    end
    rxd_drv = 1'b1;
  endtask

  task automatic rx_idle_check(input logic [9:0] want);
    repeat (3 * per) @(negedge clk);
    chk(exp_q.size() == 0, "R9 one done per frame", 32'(exp_q.size()), 32'h0);
    chk(rx_data == want, "R9 word held after done", 32'(rx_data), 32'(want));
    chk(rx_armed == 1'b1, "R9 rearmed", 32'(rx_armed), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; div_we = 1'b0; div_wdata = '0; rx_len10 = 1'b0;
    tx_we = 1'b0; tx_wdata = '0; rxd_drv = 1'b1; loop_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", 32'(txd), 32'h1);
    chk(tx_busy == 1'b0, "R1 not busy", 32'(tx_busy), 32'h0);
    chk(tx_rej == 1'b0, "R1 no reject", 32'(tx_rej), 32'h0);
    chk(rx_armed == 1'b1, "R1 armed", 32'(rx_armed), 32'h1);
    chk(rx_done == 1'b0, "R1 no done", 32'(rx_done), 32'h0);
    chk(rx_data == 10'h0, "R1 rx_data zero", 32'(rx_data), 32'h0);

    set_div(23);
    // R2 R3 plain frame
    tx_frame({6'b0, 1'b1, 8'hA5, 1'b0}, -1, 1'b0);
    // R4 mid-frame write
    tx_frame({6'b0, 1'b1, 8'h3C, 1'b0}, 3, 1'b0);
    // R4 write on the emptying edge
    tx_frame({6'b0, 1'b1, 8'h5A, 1'b0}, -1, 1'b1);

    // R7 R8 R9 short register, back-to-back frames
    rx_send({6'b0, 1'b1, 8'hC3, 1'b0}, 10);
    rx_send({6'b0, 1'b1, 8'h5A, 1'b0}, 10);
    rx_idle_check({2'b01, 8'h5A});

    // R6 glitch of two clocks
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (2) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (3 * per) @(negedge clk);
    chk(rx_armed == 1'b1, "R6 glitch ignored", 32'(rx_armed), 32'h1);
    chk(rx_data == {2'b01, 8'h5A}, "R6 word untouched by glitch", 32'(rx_data), 32'h15A);
    rx_send({6'b0, 1'b1, 8'h0F, 1'b0}, 10);
    rx_idle_check({2'b01, 8'h0F});

    // R8 long register
    rx_len10 = 1'b1;
    rx_send({5'b0, 1'b1, 1'b1, 8'h96, 1'b0}, 11);
    rx_idle_check({2'b11, 8'h96});
    rx_len10 = 1'b0;

    // R5 new divisor, loopback of transmitter into receiver
    set_div(11);
    loop_en = 1'b1;
    exp_q.push_back({2'b01, 8'h71});
    tx_frame({6'b0, 1'b1, 8'h71, 1'b0}, -1, 1'b0);
    rx_idle_check({2'b01, 8'h71});
    loop_en = 1'b0;

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule